// File: doc/BRIEF.md
# Serial Control Register Target

This block is a two-wire serial bus target (I2C compatible, 7-bit addressing) that owns a small file of 8-bit control registers. A host reaches the registers by sending the target's device address, then a 16-bit register address in two bytes with the low byte first, then one or more data bytes. The register pointer advances by one after each data byte. A read starts with a write that only loads the pointer and ends with a STOP. A new START with the read address then returns bytes from that pointer, and the pointer advances after each byte.

The bus lines are oversampled by the system clock through a short synchronizer. The target never drives SDA high. It raises an open-drain pull-down enable, and board pull-ups supply the high level. Every register is visible to the rest of the chip on one flat parallel bus. One register holds a self-clearing bit that returns all the other registers to their power-up values. Another register carries a read-only die identifier in its upper six bits.

Top module: `i2cRegTarget`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal the device address 0x5D, so the first byte is 0xBA to write or 0xBB to read. After any other address byte it gives no acknowledge and leaves SDA released until the next START.
- R2: In a write, the two bytes after the address byte form the register pointer. The first of them is bits 7:0 and the second is bits 15:8.
- R3: The target acknowledges every byte it accepts by pulling SDA low (sda_oe_o = 1) during the ninth SCL clock. It changes SDA only while SCL is low.
- R4: Each data byte in a write goes to the register at the pointer, and the pointer then advances by one.
- R5: A read returns bytes most significant bit first, starting at the pointer, and the pointer advances by one after each byte.
- R6: When the host does not acknowledge a read byte (SDA high in the ninth clock), the read ends. The target then drives nothing until the next START.
- R7: After reset every register holds its default value: 0x0802=0xD0, 0x0803=0xCC, 0x0804=0x04, 0x0805=0x10, 0x0810–0x0813=0xE0, 0x0814–0x0817=0x80, 0x0818=0x94, 0x081E=0x16, 0x0819={die ID,00}, and every other register 0x00.
- R8: Registers exist only at 0x0800–0x0805 and 0x0810–0x081F. Data written outside these windows is acknowledged and discarded, and a read there returns 0x00.
- R9: A data byte with bit 0 set that is written to 0x081F reloads every other register with its default on the same clock edge. 0x081F keeps bits 7:1 of that byte, and its bit 0 reads 0.
- R10: A software reload does not end the bus transfer. Later data bytes of the same write are still acknowledged and the pointer keeps advancing.
- R11: Bits 7:2 of 0x0819 always read the die ID (parameter, default 6'h2B) and ignore writes. Bits 1:0 of 0x0819 are writable.
- R12: A STOP or a repeated START at any point, even in the middle of a byte, ends the current transfer. The target then waits for a new address byte.
- R13: regs_o carries the register at 0x0800+i in bits [8i+7:8i] for i = 0..5, and the register at 0x0810+j in bits [8(6+j)+7:8(6+j)] for j = 0..15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | 176 | All register contents, layout as in R13 |

## Verification
Two things can happen on the same clock edge. A bus write to the reset register stores that register's own upper bits, and the reload of every other register happens at the same time. The bench provokes this with a burst that starts at 0x081E and sends 0x55 and then 0xA5. It judges the result at the parallel outputs and by readback: 0x081E must be back at its default, 0x081F must hold 0xA4, and the next byte in the same burst must still be acknowledged.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  typedef struct packed {
    logic        wrEn;
    logic [15:0] addr;
    logic [7:0]  data;
  } busStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_TXNEXT
  } busState_t;

  typedef enum logic [1:0] {
    PH_DEV, PH_ALO, PH_AHI, PH_DATA
  } rxPhase_t;

  localparam logic [15:0] ADDR_DIE_ID = 16'h0819;
  localparam logic [15:0] ADDR_SWRST  = 16'h081F;

  // Power-up value of each register, by register address.
  function automatic logic [7:0] regDefault(input logic [15:0] a);
    logic [7:0] v;
    if (a >= 16'h0810 && a <= 16'h0813)      v = 8'hE0;
    else if (a >= 16'h0814 && a <= 16'h0817) v = 8'h80;
    else begin
      case (a)
        16'h0802: v = 8'hD0;
        16'h0803: v = 8'hCC;
        16'h0804: v = 8'h04;
        16'h0805: v = 8'h10;
        16'h0818: v = 8'h94;
        16'h081E: v = 8'h16;
        default:  v = 8'h00;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/i2cLineSync.sv
module i2cLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], scl_i};
      sdaPipe <= {sdaPipe[STAGES-2:0], sda_i};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[STAGES-1];
  assign sdaS     = sdaPipe[STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/i2cBusCtrl.sv
module i2cBusCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5D
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sdaS,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic [7:0]  rdData,
  output logic [15:0] rdAddr,
  output busStrobe_t  strobe,
  output logic        sdaOe
);
  busState_t   state;
  rxPhase_t    phase;
  logic [2:0]  bitCnt;
  logic        rxFull;
  logic        isRead;
  logic [7:0]  shiftQ;
  logic [7:0]  txQ;
  logic [15:0] ptr;

  assign rdAddr = ptr;

  always_comb begin
    strobe.wrEn = (state == ST_RX) && rxFull && sclFall && (phase == PH_DATA);
    strobe.addr = ptr;
    strobe.data = shiftQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      phase  <= PH_DEV;
      bitCnt <= '0;
      rxFull <= 1'b0;
      isRead <= 1'b0;
      shiftQ <= '0;
      txQ    <= '0;
      ptr    <= '0;
      sdaOe  <= 1'b0;
    end else if (startDet) begin
      state  <= ST_RX;
      phase  <= PH_DEV;
      bitCnt <= '0;
      rxFull <= 1'b0;
      sdaOe  <= 1'b0;
    end else if (stopDet) begin
      state  <= ST_IDLE;
      rxFull <= 1'b0;
      sdaOe  <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && !rxFull) begin
            shiftQ <= {shiftQ[6:0], sdaS};
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) rxFull <= 1'b1;
          end else if (sclFall && rxFull) begin
            rxFull <= 1'b0;
            bitCnt <= '0;
            case (phase)
              PH_DEV: begin
                if (shiftQ[7:1] == DEV_ADDR) begin
                  isRead <= shiftQ[0];
                  phase  <= PH_ALO;
                  sdaOe  <= 1'b1;
                  state  <= ST_RXACK;
                end else begin
                  state <= ST_IDLE;
                end
              end
              PH_ALO: begin
                ptr[7:0] <= shiftQ;
                phase    <= PH_AHI;
                sdaOe    <= 1'b1;
                state    <= ST_RXACK;
              end
              PH_AHI: begin
                ptr[15:8] <= shiftQ;
                phase     <= PH_DATA;
                sdaOe     <= 1'b1;
                state     <= ST_RXACK;
              end
              default: begin
                ptr   <= ptr + 16'd1;
                sdaOe <= 1'b1;
                state <= ST_RXACK;
              end
            endcase
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            if (isRead) begin
              txQ    <= rdData;
              sdaOe  <= ~rdData[7];
              ptr    <= ptr + 16'd1;
              bitCnt <= '0;
              state  <= ST_TX;
            end else begin
              sdaOe <= 1'b0;
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 3'd7) begin
              sdaOe <= 1'b0;
              state <= ST_TXACK;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              txQ    <= {txQ[6:0], 1'b0};
              sdaOe  <= ~txQ[6];
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) state <= sdaS ? ST_IDLE : ST_TXNEXT;
        end
        ST_TXNEXT: begin
          if (sclFall) begin
            txQ    <= rdData;
            sdaOe  <= ~rdData[7];
            ptr    <= ptr + 16'd1;
            bitCnt <= '0;
            state  <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cRegFile.sv
module i2cRegFile
  import i2cRegPkg::*;
#(
  parameter logic [5:0]  DIE_ID = 6'h2B,
  parameter logic [15:0] A_BASE = 16'h0800,
  parameter int          A_LEN  = 6,
  parameter logic [15:0] B_BASE = 16'h0810,
  parameter int          B_LEN  = 16,
  localparam int         NREG   = A_LEN + B_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  busStrobe_t        strobe,
  input  logic [15:0]       rdAddr,
  output logic [7:0]        rdData,
  output logic [NREG*8-1:0] regsFlat
);
  function automatic logic [15:0] regAddrOf(input int i);
    logic [15:0] r;
    if (i < A_LEN) r = A_BASE + 16'(i);
    else           r = B_BASE + 16'(i - A_LEN);
    return r;
  endfunction

  logic swReload;
  assign swReload = strobe.wrEn && (strobe.addr == ADDR_SWRST) && strobe.data[0];

  for (genvar g = 0; g < NREG; g++) begin : gCell
    localparam logic [15:0] CELL_ADDR = regAddrOf(g);
    localparam logic [7:0]  CELL_DEF  =
      (CELL_ADDR == ADDR_DIE_ID) ? {DIE_ID, 2'b00} : regDefault(CELL_ADDR);
    logic [7:0] cellQ;
    logic hit;
    assign hit = strobe.wrEn && (strobe.addr == CELL_ADDR);

    if (CELL_ADDR == ADDR_SWRST) begin : gSwRst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cellQ <= CELL_DEF;
        else if (hit) cellQ <= {strobe.data[7:1], 1'b0};
      end
    end else if (CELL_ADDR == ADDR_DIE_ID) begin : gDieId
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cellQ <= CELL_DEF;
        else if (swReload) cellQ <= CELL_DEF;
        else if (hit)      cellQ <= {DIE_ID, strobe.data[1:0]};
      end
    end else begin : gPlain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cellQ <= CELL_DEF;
        else if (swReload) cellQ <= CELL_DEF;
        else if (hit)      cellQ <= strobe.data;
      end
    end

    assign regsFlat[g*8 +: 8] = cellQ;
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rdAddr == regAddrOf(i)) rdData = regsFlat[i*8 +: 8];
    end
  end
endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cRegPkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h5D,
  parameter logic [5:0]  DIE_ID      = 6'h2B,
  parameter logic [15:0] A_BASE      = 16'h0800,
  parameter int          A_LEN       = 6,
  parameter logic [15:0] B_BASE      = 16'h0810,
  parameter int          B_LEN       = 16,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_oe_o,
  output logic [(A_LEN+B_LEN)*8-1:0]   regs_o
);
  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic [15:0] rdAddr;
  logic [7:0]  rdData;
  busStrobe_t  strobe;

  i2cLineSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cBusCtrl #(.DEV_ADDR(DEV_ADDR)) uCtrl (
    .clk(clk), .rst_n(rst_n), .sdaS(sdaS), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .rdData(rdData), .rdAddr(rdAddr), .strobe(strobe), .sdaOe(sda_oe_o)
  );

  i2cRegFile #(
    .DIE_ID(DIE_ID), .A_BASE(A_BASE), .A_LEN(A_LEN),
    .B_BASE(B_BASE), .B_LEN(B_LEN)
  ) uRegs (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rdAddr(rdAddr),
    .rdData(rdData), .regsFlat(regs_o)
  );
endmodule

// File: rtl/i2cRegTargetChecker.sv
module i2cRegTargetChecker
  import i2cRegPkg::*;
#(
  parameter logic [5:0]  DIE_ID = 6'h2B,
  parameter logic [15:0] A_BASE = 16'h0800,
  parameter int          A_LEN  = 6,
  parameter logic [15:0] B_BASE = 16'h0810,
  parameter int          B_LEN  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sclS,
  input logic                       startDet,
  input logic                       stopDet,
  input logic                       sdaOe,
  input busStrobe_t                 strobe,
  input logic [(A_LEN+B_LEN)*8-1:0] regs
);
  function automatic int idxOf(input logic [15:0] a);
    if (a >= A_BASE && a < A_BASE + 16'(A_LEN)) return int'(a - A_BASE);
    return A_LEN + int'(a - B_BASE);
  endfunction

  localparam int GAIN_IDX = idxOf(16'h0810);
  localparam int DIE_IDX  = idxOf(ADDR_DIE_ID);

  // R3: the acknowledge follows every accepted data byte
  assert_ack_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrEn |=> sdaOe);

  // R3: SDA is pulled low only while SCL is low
  assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdaOe) |-> !sclS);

  // R4: a written byte appears at the parallel output
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && strobe.addr == 16'h0810 && !(strobe.data[0] && 1'b0))
    |=> regs[GAIN_IDX*8 +: 8] == $past(strobe.data));

  // R9: setting the reset bit returns the other registers to defaults
  assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && strobe.addr == ADDR_SWRST && strobe.data[0])
    |=> regs[GAIN_IDX*8 +: 8] == 8'hE0);

  // R11: the die identifier survives writes to its register
  assert_die_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.wrEn && strobe.addr == ADDR_DIE_ID)
    |=> regs[DIE_IDX*8+2 +: 6] == DIE_ID);

  // R12: START or STOP releases SDA
  assert_release_on_cond_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (startDet || stopDet) |=> !sdaOe);

  // R13: register outputs move only after a write strobe
  assert_regs_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobe.wrEn) |-> $stable(regs));
endmodule

bind i2cRegTarget i2cRegTargetChecker #(
  .DIE_ID(DIE_ID), .A_BASE(A_BASE), .A_LEN(A_LEN),
  .B_BASE(B_BASE), .B_LEN(B_LEN)
) uChk (
  .clk(clk), .rst_n(rst_n), .sclS(sclS), .startDet(startDet),
  .stopDet(stopDet), .sdaOe(sda_oe_o), .strobe(strobe), .regs(regs_o)
);

// File: tb/i2cRegTarget_test.sv
module i2cRegTarget_test;
  localparam int Q = 10;
  localparam int NREG = 22;
  localparam logic [5:0] DIE = 6'h2B;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterScl = 1'b1;
  logic masterSda = 1'b1;
  logic sdaOe;
  logic sdaLine;
  logic [NREG*8-1:0] regs;
  int checks = 0;
  int errors = 0;
  logic [7:0] defs  [NREG];
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  assign sdaLine = masterSda & ~sdaOe;

  i2cRegTarget uut (
    .clk(clk), .rst_n(rstN), .scl_i(masterScl), .sda_i(sdaLine),
    .sda_oe_o(sdaOe), .regs_o(regs)
  );

  function automatic int idxOf(input logic [15:0] a);
    if (a >= 16'h0800 && a <= 16'h0805) return int'(a - 16'h0800);
    if (a >= 16'h0810 && a <= 16'h081F) return 6 + int'(a - 16'h0810);
    return -1;
  endfunction

  function automatic logic [7:0] expRead(input logic [15:0] a);
    int i;
    i = idxOf(a);
    return (i < 0) ? 8'h00 : model[i];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  task automatic modelWrite(input logic [15:0] a, input logic [7:0] d);
    int i;
    i = idxOf(a);
    if (a == 16'h081F) begin
      if (d[0]) for (int k = 0; k < NREG; k++) model[k] = defs[k];
      model[21] = {d[7:1], 1'b0};
    end else if (a == 16'h0819) begin
      model[i] = {DIE, d[1:0]};
    end else if (i >= 0) begin
      model[i] = d;
    end
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < NREG; i++) check(req, regs[i*8 +: 8], model[i]);
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    masterSda = 1'b0; waitQ();
    masterScl = 1'b0; waitQ();
  endtask

  task automatic i2cRestart();
    masterSda = 1'b1; waitQ();
    masterScl = 1'b1; waitQ();
    masterSda = 1'b0; waitQ();
    masterScl = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    masterSda = 1'b0; waitQ();
    masterScl = 1'b1; waitQ();
    masterSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      masterSda = b[i]; waitQ();
      masterScl = 1'b1; waitQ(); waitQ();
      masterScl = 1'b0; waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    sendBits(b, 8);
    masterSda = 1'b1; waitQ();
    masterScl = 1'b1; waitQ();
    ack = sdaLine; waitQ();
    masterScl = 1'b0; waitQ();
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      masterScl = 1'b1; waitQ();
      b[i] = sdaLine; waitQ();
      masterScl = 1'b0; waitQ(); waitQ();
    end
    masterSda = nack; waitQ();
    masterScl = 1'b1; waitQ(); waitQ();
    masterScl = 1'b0; waitQ();
    masterSda = 1'b1;
  endtask

  task automatic writeSeq(input logic [15:0] a, input logic [7:0] d[4], input int n);
    logic ack;
    i2cStart();
    sendByte(8'hBA, ack); check("R1 write address ack", {7'b0, ack}, 8'h00);
    sendByte(a[7:0], ack); check("R3 pointer low ack", {7'b0, ack}, 8'h00);
    sendByte(a[15:8], ack); check("R3 pointer high ack", {7'b0, ack}, 8'h00);
    for (int k = 0; k < n; k++) begin
      sendByte(d[k], ack); check("R3 data ack", {7'b0, ack}, 8'h00);
      modelWrite(a + 16'(k), d[k]);
    end
    i2cStop();
  endtask

  task automatic readSeq(input logic [15:0] a, input int n, input string req);
    logic ack;
    logic [7:0] b;
    i2cStart();
    sendByte(8'hBA, ack);
    sendByte(a[7:0], ack);
    sendByte(a[15:8], ack);
    i2cStop();
    i2cStart();
    sendByte(8'hBB, ack); check("R1 read address ack", {7'b0, ack}, 8'h00);
    for (int k = 0; k < n; k++) begin
      recvByte(k == n - 1, b);
      check(req, b, expRead(a + 16'(k)));
    end
    for (int p = 0; p < 2; p++) begin
      masterScl = 1'b1; waitQ();
      check("R6 SDA released after NACK", {7'b0, sdaOe}, 8'h00);
      waitQ();
      masterScl = 1'b0; waitQ();
    end
    i2cStop();
  endtask

  task automatic testReset();
    checkAll("R7 R13 reset value");
    check("R3 idle SDA released", {7'b0, sdaOe}, 8'h00);
  endtask

  task automatic testWrite();
    writeSeq(16'h0810, '{8'h11, 8'h22, 8'h33, 8'h00}, 3);
    checkAll("R4 R13 burst write");
    writeSeq(16'h0802, '{8'h5C, 8'h00, 8'h00, 8'h00}, 1);
    check("R2 low byte first pointer", regs[2*8 +: 8], 8'h5C);
  endtask

  task automatic testRead();
    readSeq(16'h0811, 3, "R5 burst read");
  endtask

  task automatic testBadAddr();
    logic ack;
    i2cStart();
    sendByte(8'hA4, ack); check("R1 foreign address NACK", {7'b0, ack}, 8'h01);
    sendByte(8'h10, ack); check("R1 stays silent", {7'b0, ack}, 8'h01);
    sendByte(8'h08, ack); check("R1 stays silent", {7'b0, ack}, 8'h01);
    sendByte(8'h77, ack); check("R1 stays silent", {7'b0, ack}, 8'h01);
    i2cStop();
    checkAll("R1 nothing written");
  endtask

  task automatic testWindow();
    writeSeq(16'h0805, '{8'h5A, 8'h99, 8'h00, 8'h00}, 2);
    checkAll("R8 gap write discarded");
    readSeq(16'h0805, 2, "R8 gap reads zero");
  endtask

  task automatic testDieId();
    writeSeq(16'h0819, '{8'hFF, 8'h00, 8'h00, 8'h00}, 1);
    check("R11 die ID kept", regs[15*8 +: 8], {DIE, 2'b11});
    readSeq(16'h0819, 1, "R11 die ID readback");
  endtask

  task automatic testSoftReset();
    writeSeq(16'h081E, '{8'h55, 8'hA5, 8'h3C, 8'h00}, 3);
    check("R9 reset register keeps upper bits", regs[21*8 +: 8], 8'hA4);
    check("R9 0x081E reloaded", regs[20*8 +: 8], 8'h16);
    checkAll("R9 R10 reload");
    readSeq(16'h081F, 1, "R9 readback");
  endtask

  task automatic testRestart();
    logic ack;
    i2cStart();
    sendByte(8'hBA, ack);
    sendByte(8'h00, ack);
    i2cRestart();
    sendByte(8'hBA, ack); check("R12 address after restart", {7'b0, ack}, 8'h00);
    sendByte(8'h03, ack);
    sendByte(8'h08, ack);
    sendByte(8'hEE, ack);
    i2cStop();
    modelWrite(16'h0803, 8'hEE);
    check("R12 write after restart", regs[3*8 +: 8], 8'hEE);
    i2cStart();
    sendBits(8'hBA, 4);
    i2cStop();
    writeSeq(16'h0800, '{8'h42, 8'h00, 8'h00, 8'h00}, 1);
    check("R12 write after aborted byte", regs[0 +: 8], 8'h42);
  endtask

  initial begin
    defs = '{8'h00, 8'h00, 8'hD0, 8'hCC, 8'h04, 8'h10,
             8'hE0, 8'hE0, 8'hE0, 8'hE0, 8'h80, 8'h80, 8'h80, 8'h80,
             8'h94, {DIE, 2'b00}, 8'h00, 8'h00, 8'h00, 8'h00, 8'h16, 8'h00};
    for (int k = 0; k < NREG; k++) model[k] = defs[k];
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitQ();
    testReset();
    testWrite();
    testRead();
    testBadAddr();
    testWindow();
    testDieId();
    testSoftReset();
    testRestart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R12 actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule